// File: doc/BRIEF.md
# Single-Cycle Memory-Mapped Bus Decoder

This block connects a CPU core to the system bus and sorts every access by address. A single 16-bit address space serves two kinds of target. A small window at the very top of the space holds peripheral interface registers. All lower addresses go to main memory. The CPU reaches both kinds with the same read and write strobes, because no separate I/O instructions exist. The block raises the chip select of the target the address picks. For a read it drives the selected word onto the CPU's bidirectional data bus. For a write it hands the bus value to memory or stores it in the addressed peripheral register.

Every access finishes within one clock period, and there is no wait or stall handshake. Memory read data returns combinationally during the strobe cycle. A write to a peripheral register is captured at the clock edge that ends the access.

Top module: `bus_steer`

## Requirements
- R1: With exactly one strobe asserted, an address in 0xFFF0 to 0xFFFF raises per_cs_o and keeps mem_cs_o low. Every lower address raises mem_cs_o and keeps per_cs_o low.
- R2: During a valid read, rd_oe_o is high and data_io carries the selected word in the same cycle. For memory that word is mem_rdata_i. rd_oe_o is never high without rd_i.
- R3: A valid write to an implemented peripheral register (0xFFF0 to 0xFFF3) stores the data_io value at the clock edge that ends the access. A later read of that address returns it.
- R4: A valid write to a memory address raises mem_we_o and presents the data_io value on mem_wdata_o in the same cycle.
- R5: When rd_i and wr_i are both high, the access is ignored. Both chip selects, mem_we_o and rd_oe_o stay low, and no peripheral register changes.
- R6: With neither strobe asserted, both chip selects and rd_oe_o are low and the block leaves data_io undriven.
- R7: Addresses 0xFFF4 to 0xFFFF are unimplemented registers. A read there returns 0x0000, and a write there changes no implemented register.
- R8: After reset every implemented peripheral register reads 0x0000.
- R9: A write to the peripheral window never raises mem_we_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| rd_i | input | 1 | CPU read strobe |
| wr_i | input | 1 | CPU write strobe |
| data_io | inout | 16 | CPU bidirectional data bus |
| mem_addr_o | output | 16 | Address to main memory |
| mem_cs_o | output | 1 | Main memory chip select |
| mem_we_o | output | 1 | Main memory write enable |
| mem_wdata_o | output | 16 | Write data to main memory |
| mem_rdata_i | input | 16 | Read data from main memory |
| per_cs_o | output | 1 | Peripheral window chip select |
| rd_oe_o | output | 1 | High while the block drives data_io |

## Verification
The hardest case to reach is an access with both strobes high. It must leave no trace, yet the state it could corrupt sits inside the peripheral registers, out of direct view. The stimulus first writes known values to the registers. It then issues a double-strobe access, with fresh data on the bus, to one of those same addresses. Clean reads follow at once, so any leaked capture shows on the data bus. Writes to unimplemented window addresses are checked the same way, and memory-side boundaries are probed at 0xFFEF and 0xFFF0.

// File: rtl/bus_pkg.sv
package bus_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_MEM  = 2'd1,
    TGT_PER  = 2'd2
  } tgt_e;
endpackage

// File: rtl/addr_decode.sv
module addr_decode
  import bus_pkg::*;
#(
  parameter int AW       = 16,
  parameter int WIN_BITS = 4
) (
  input  logic [AW-1:0]       addr_i,
  input  logic                rd_i,
  input  logic                wr_i,
  output tgt_e                tgt_o,
  output logic [WIN_BITS-1:0] idx_o
);
  logic valid, in_win;

  // exactly one strobe makes an access; both together is dropped
  assign valid  = rd_i ^ wr_i;
  assign in_win = &addr_i[AW-1:WIN_BITS];
  assign idx_o  = addr_i[WIN_BITS-1:0];

  always_comb begin
    if (!valid)      tgt_o = TGT_NONE;
    else if (in_win) tgt_o = TGT_PER;
    else             tgt_o = TGT_MEM;
  end
endmodule

// File: rtl/periph_regs.sv
module periph_regs #(
  parameter int DW       = 16,
  parameter int WIN_BITS = 4,
  parameter int NUM_REGS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [WIN_BITS-1:0] idx_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o
);
  logic [DW-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= '0;
      else if (we_i && idx_i == WIN_BITS'(g))       regs_q[g] <= wdata_i;
    end
  end

  // unimplemented slots fall through to zero
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx_i == WIN_BITS'(i)) rdata_o = regs_q[i];
  end
endmodule

// File: rtl/read_steer.sv
module read_steer
  import bus_pkg::*;
#(
  parameter int DW = 16
) (
  input  tgt_e          tgt_i,
  input  logic          rd_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [DW-1:0] per_rdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          oe_o
);
  assign oe_o    = rd_i && (tgt_i != TGT_NONE);
  assign rdata_o = (tgt_i == TGT_PER) ? per_rdata_i : mem_rdata_i;
endmodule

// File: rtl/bus_steer.sv
module bus_steer
  import bus_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int WIN_BITS = 4,
  parameter int NUM_REGS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  inout  wire  [DW-1:0] data_io,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_cs_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          per_cs_o,
  output logic          rd_oe_o
);
  tgt_e                tgt;
  logic [WIN_BITS-1:0] idx;
  logic [DW-1:0]       per_rdata, rdata;

  addr_decode #(.AW(AW), .WIN_BITS(WIN_BITS)) u_dec (
    .addr_i (addr_i),
    .rd_i   (rd_i),
    .wr_i   (wr_i),
    .tgt_o  (tgt),
    .idx_o  (idx)
  );

  periph_regs #(.DW(DW), .WIN_BITS(WIN_BITS), .NUM_REGS(NUM_REGS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (per_cs_o && wr_i),
    .idx_i   (idx),
    .wdata_i (data_io),
    .rdata_o (per_rdata)
  );

  read_steer #(.DW(DW)) u_rd (
    .tgt_i       (tgt),
    .rd_i        (rd_i),
    .mem_rdata_i (mem_rdata_i),
    .per_rdata_i (per_rdata),
    .rdata_o     (rdata),
    .oe_o        (rd_oe_o)
  );

  assign mem_addr_o  = addr_i;
  assign mem_cs_o    = (tgt == TGT_MEM);
  assign per_cs_o    = (tgt == TGT_PER);
  assign mem_we_o    = mem_cs_o && wr_i;
  assign mem_wdata_o = data_io;
  assign data_io     = rd_oe_o ? rdata : 'z;
endmodule

// File: rtl/bus_steer_chk.sv
module bus_steer_chk #(
  parameter int AW       = 16,
  parameter int WIN_BITS = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          rd_i,
  input logic          wr_i,
  input logic          mem_cs_o,
  input logic          mem_we_o,
  input logic          per_cs_o,
  input logic          rd_oe_o
);
  localparam logic [AW-1:0] WinBase = {{(AW-WIN_BITS){1'b1}}, {WIN_BITS{1'b0}}};

  // R1
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_cs_o, per_cs_o}));

  // R1
  per_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_cs_o |-> addr_i >= WinBase);

  // R2
  oe_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_oe_o |-> rd_i && (mem_cs_o || per_cs_o));

  // R5
  dual_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && wr_i) |-> !mem_cs_o && !per_cs_o && !mem_we_o && !rd_oe_o);

  // R6
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !wr_i) |-> !mem_cs_o && !per_cs_o && !rd_oe_o);

  // R9
  per_no_mem_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !per_cs_o && addr_i < WinBase);
endmodule

bind bus_steer bus_steer_chk #(.AW(AW), .WIN_BITS(WIN_BITS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .rd_i     (rd_i),
  .wr_i     (wr_i),
  .mem_cs_o (mem_cs_o),
  .mem_we_o (mem_we_o),
  .per_cs_o (per_cs_o),
  .rd_oe_o  (rd_oe_o)
);

// File: tb/sim_bus_steer.sv
module sim_bus_steer;
  typedef struct {
    string       req;
    logic        mem_cs;
    logic        per_cs;
    logic        mem_we;
    logic        oe;
    logic [15:0] data;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [15:0] drv = '0;
  wire  [15:0] bus;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_cs, mem_we, per_cs, rd_oe;

  item_t       q[$];
  logic [15:0] model [4];
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  assign bus       = wr ? drv : 'z;
  assign mem_rdata = mem_addr ^ 16'h5A3C;

  bus_steer u0 (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .rd_i (rd), .wr_i (wr),
    .data_io (bus), .mem_addr_o (mem_addr), .mem_cs_o (mem_cs),
    .mem_we_o (mem_we), .mem_wdata_o (mem_wdata), .mem_rdata_i (mem_rdata),
    .per_cs_o (per_cs), .rd_oe_o (rd_oe)
  );

  task automatic access(input string req, input logic [15:0] a,
                        input logic r, input logic w, input logic [15:0] d);
    item_t it;
    logic  valid, win;
    @(posedge clk); #2;
    addr = a; rd = r; wr = w; drv = d;
    valid = r ^ w;
    win   = (a >= 16'hFFF0);
    it.req    = req;
    it.mem_cs = valid && !win;
    it.per_cs = valid && win;
    it.mem_we = valid && !win && w;
    it.oe     = valid && r;
    if (!win)            it.data = w ? d : (a ^ 16'h5A3C);
    else if (a < 16'hFFF4) it.data = model[a[1:0]];
    else                 it.data = 16'h0000;
    if (valid && win && w && a < 16'hFFF4) model[a[1:0]] = d;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    logic  ok;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        ok = (mem_cs == it.mem_cs) && (per_cs == it.per_cs) &&
             (mem_we == it.mem_we) && (rd_oe == it.oe);
        if (it.oe && bus != it.data) ok = 1'b0;
        if (it.mem_we && mem_wdata != it.data) ok = 1'b0;
        n_chk++;
        if (!ok) begin
          n_fail++;
          $display("FAIL %s addr=%h act cs=%b/%b we=%b oe=%b bus=%h wd=%h exp cs=%b/%b we=%b oe=%b data=%h",
                   it.req, addr, mem_cs, per_cs, mem_we, rd_oe, bus, mem_wdata,
                   it.mem_cs, it.per_cs, it.mem_we, it.oe, it.data);
        end
      end
    end
  end

  initial begin : watchdog
    #1000000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R8 reset contents
    for (int i = 0; i < 4; i++) access("R8", 16'hFFF0 + 16'(i), 1'b1, 1'b0, '0);
    // R6 idle
    access("R6", 16'h0100, 1'b0, 1'b0, 16'h1111);
    access("R6", 16'hFFF1, 1'b0, 1'b0, 16'h2222);
    // R1 R2 memory reads incl. window boundary
    access("R1", 16'h0000, 1'b1, 1'b0, '0);
    access("R2", 16'h1234, 1'b1, 1'b0, '0);
    access("R1", 16'hFFEF, 1'b1, 1'b0, '0);
    // R4 memory writes
    access("R4", 16'h0040, 1'b0, 1'b1, 16'hCAFE);
    access("R4", 16'hFFEF, 1'b0, 1'b1, 16'h0F0F);
    // R3 R9 register writes then readback
    access("R9", 16'hFFF0, 1'b0, 1'b1, 16'hA001);
    access("R3", 16'hFFF1, 1'b0, 1'b1, 16'h1234);
    access("R3", 16'hFFF3, 1'b0, 1'b1, 16'hBEEF);
    for (int i = 0; i < 4; i++) access("R3", 16'hFFF0 + 16'(i), 1'b1, 1'b0, '0);
    // R7 unimplemented slots
    access("R7", 16'hFFF4, 1'b0, 1'b1, 16'h7777);
    access("R7", 16'hFFFF, 1'b0, 1'b1, 16'h8888);
    access("R7", 16'hFFF4, 1'b1, 1'b0, '0);
    access("R7", 16'hFFFF, 1'b1, 1'b0, '0);
    for (int i = 0; i < 4; i++) access("R7", 16'hFFF0 + 16'(i), 1'b1, 1'b0, '0);
    // R5 both strobes, then confirm registers untouched
    access("R5", 16'hFFF1, 1'b1, 1'b1, 16'hDEAD);
    access("R5", 16'hFFF2, 1'b1, 1'b1, 16'h5555);
    access("R5", 16'h0200, 1'b1, 1'b1, 16'h6666);
    for (int i = 0; i < 4; i++) access("R5", 16'hFFF0 + 16'(i), 1'b1, 1'b0, '0);
    // R1 top of window
    access("R1", 16'hFFFF, 1'b1, 1'b0, '0);
    access("R1", 16'hFFF0, 1'b1, 1'b0, '0);
    @(posedge clk); #2 rd = 1'b0; wr = 1'b0;
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule